// File: doc/BRIEF.md
# Safe-Reset GPIO Port Controller

This block is a small bank of general-purpose pins that a processor controls through a simple register bus. Software picks each pin's direction, its output level, and its pull resistor. The pull resistor can point up or down, or it can be turned off. Set and clear addresses let software raise or lower single output bits without a read-modify-write sequence. Each pin's input level passes through a two-flop synchronizer and can then be read back.

The main concern is safe behaviour around reset. While the active-low system reset is held low, every pad is an input with its output driver off and a pull-down applied. This holds whatever the registers contain. When reset releases, every register has a value that keeps that same pad state, so the pads do not glitch. The output data reaches a pad only after software sets that pin's direction bit.

Top module: `safe_gpio_port`

## Requirements
- R1: While `rst_n` is 0, `pad_oe` and `pad_out` are all zeros, even if the registers held other values before reset was asserted.
- R2: While `rst_n` is 0, `pad_pull_en` is all ones and `pad_pull_up` is all zeros (pull-down on every pin).
- R3: After reset, the direction (0x0), data-out (0x8), pull-disable (0x14) and pull-select (0x18) registers read as zero.
- R4: `pad_oe` equals the direction register. `pad_out` is the data-out register ANDed with the direction register, so data-out has no effect on a pin whose direction bit is 0 (1 = output).
- R5: A write to 0xC sets every data-out bit where the written value is 1 and leaves every other bit unchanged.
- R6: A write to 0x10 clears every data-out bit where the written value is 1 and leaves every other bit unchanged.
- R7: A read at 0xC or at 0x10 returns the current data-out value.
- R8: A read at 0x4 returns `pad_in` through a two-flop synchronizer. A change on `pad_in` made just after clock edge E0 first shows on `rd_data` after edge E2.
- R9: `pad_pull_en` bit i is 1 exactly when direction bit i is 0 and pull-disable bit i is 0. `pad_pull_up` follows the pull-select register (1 = pull-up, 0 = pull-down).
- R10: Writes to 0x4 and to unmapped or non-word-aligned addresses change no register. Reads of unmapped or non-word-aligned addresses return 0.
- R11: In the first cycle after reset releases, and before any write, the pads stay in the reset-phase state: `pad_oe` is 0, `pad_pull_en` is all ones and `pad_pull_up` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| addr | input | ADDR_W | Byte address of the register |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | PINS | Write data |
| rd_data | output | PINS | Read data for `addr`, combinational |
| pad_in | input | PINS | Levels seen at the pads |
| pad_oe | output | PINS | Output driver enable per pin |
| pad_out | output | PINS | Output level per pin |
| pad_pull_en | output | PINS | Pull resistor enable per pin |
| pad_pull_up | output | PINS | Pull direction per pin, 1 = up |

## Verification
Register writes land on the rising edge that samples `wr_en`. The pad outputs and the read data follow from the registers through logic only, so the effect of a write is due on the next falling edge. The only result with extra delay is the data-in read, which is due two rising edges after `pad_in` changes. The bench checks the old value at the falling edges before that point and the new value only from the second one on. Stimulus is driven just after a rising edge, and every expected item is compared at the next falling edge. Reset is applied both from power-up and again after the registers have been configured, so the forced safe state is checked against non-zero register contents.

// File: rtl/safe_gpio_pkg.sv
package safe_gpio_pkg;

    // Register selected by a decoded bus address; word index equals the encoding.
    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_DIN  = 3'd1,
        SEL_DOUT = 3'd2,
        SEL_SET  = 3'd3,
        SEL_CLR  = 3'd4,
        SEL_PDIS = 3'd5,
        SEL_PSEL = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/safe_gpio_sync.sv
module safe_gpio_sync #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] raw_in,
    output logic [PINS-1:0] sync_out
);

    typedef struct packed {
        logic [PINS-1:0] meta;
        logic [PINS-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw_in;
        s_d.stab = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_out = s_q.stab;

    // R8: second stage takes what the first stage held one cycle earlier
    a_r8_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (s_q.stab == $past(s_q.meta)));

endmodule

// File: rtl/safe_gpio_regs.sv
module safe_gpio_regs
    import safe_gpio_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PINS-1:0]   wr_data,
    input  logic [PINS-1:0]   din_sync,
    output logic [PINS-1:0]   rd_data,
    output logic [PINS-1:0]   dir,
    output logic [PINS-1:0]   dout,
    output logic [PINS-1:0]   pdis,
    output logic [PINS-1:0]   psel
);

    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] dout;
        logic [PINS-1:0] pdis;
        logic [PINS-1:0] psel;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;

    // Address decode: word aligned only, anything else is unmapped
    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            case (addr[ADDR_W-1:2])
                IDX_W'(0): sel = SEL_DIR;
                IDX_W'(1): sel = SEL_DIN;
                IDX_W'(2): sel = SEL_DOUT;
                IDX_W'(3): sel = SEL_SET;
                IDX_W'(4): sel = SEL_CLR;
                IDX_W'(5): sel = SEL_PDIS;
                IDX_W'(6): sel = SEL_PSEL;
                default:   sel = SEL_NONE;
            endcase
        end
    end

    // Next register state
    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                SEL_DIR:  r_d.dir  = wr_data;
                SEL_DOUT: r_d.dout = wr_data;
                SEL_SET:  r_d.dout = r_q.dout | wr_data;
                SEL_CLR:  r_d.dout = r_q.dout & ~wr_data;
                SEL_PDIS: r_d.pdis = wr_data;
                SEL_PSEL: r_d.psel = wr_data;
                default:  r_d      = r_q;
            endcase
        end
    end

    // Reset values: input, low, pull enabled, pull-down (same as reset phase)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Read mux
    always_comb begin
        case (sel)
            SEL_DIR:  rd_data = r_q.dir;
            SEL_DIN:  rd_data = din_sync;
            SEL_DOUT: rd_data = r_q.dout;
            SEL_SET:  rd_data = r_q.dout;
            SEL_CLR:  rd_data = r_q.dout;
            SEL_PDIS: rd_data = r_q.pdis;
            SEL_PSEL: rd_data = r_q.psel;
            default:  rd_data = '0;
        endcase
    end

    assign dir  = r_q.dir;
    assign dout = r_q.dout;
    assign pdis = r_q.pdis;
    assign psel = r_q.psel;

    // R5: every bit written as 1 through the set address ends up high
    a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SET) |=> ((r_q.dout & $past(wr_data)) == $past(wr_data)));

    // R6: every bit written as 1 through the clear address ends up low
    a_r6_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CLR) |=> ((r_q.dout & $past(wr_data)) == '0));

    // R10: a write to data-in or an unmapped address keeps every register
    a_r10_no_side_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_DIN || sel == SEL_NONE)) |=> $stable(r_q));

    // R11: right after release the pull controls match the reset phase
    a_r11_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (r_q.dir == '0 && r_q.pdis == '0 && r_q.psel == '0));

endmodule

// File: rtl/safe_gpio_padctl.sv
module safe_gpio_padctl #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] dout,
    input  logic [PINS-1:0] pdis,
    input  logic [PINS-1:0] psel,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_pull_en,
    output logic [PINS-1:0] pad_pull_up
);

    // Per-pin pad control, forced safe while system reset is low
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_comb begin
            if (!rst_n) begin
                pad_oe[i]      = 1'b0;
                pad_out[i]     = 1'b0;
                pad_pull_en[i] = 1'b1;
                pad_pull_up[i] = 1'b0;
            end else begin
                pad_oe[i]      = dir[i];
                pad_out[i]     = dir[i] & dout[i];
                pad_pull_en[i] = ~dir[i] & ~pdis[i];
                pad_pull_up[i] = psel[i];
            end
        end
    end

    // R1 / R2: safe pad state whenever reset is low
    always_comb begin
        if (!rst_n) begin
            a_r1_safe_driver: assert ((pad_oe | pad_out) == '0);
            a_r2_reset_pull: assert (pad_pull_en == '1 && pad_pull_up == '0);
        end
    end

    // R4: a driven-high pad always has its driver enabled
    a_r4_out_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R9: a driving pin never has a pull resistor enabled
    a_r9_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0);

endmodule

// File: rtl/safe_gpio_port.sv
module safe_gpio_port #(
    parameter int PINS   = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PINS-1:0]   wr_data,
    output logic [PINS-1:0]   rd_data,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_pull_en,
    output logic [PINS-1:0]   pad_pull_up
);

    logic [PINS-1:0] din_sync;
    logic [PINS-1:0] dir, dout, pdis, psel;

    safe_gpio_sync #(.PINS(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .sync_out (din_sync)
    );

    safe_gpio_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .din_sync (din_sync),
        .rd_data  (rd_data),
        .dir      (dir),
        .dout     (dout),
        .pdis     (pdis),
        .psel     (psel)
    );

    safe_gpio_padctl #(.PINS(PINS)) u_pad (
        .clk         (clk),
        .rst_n       (rst_n),
        .dir         (dir),
        .dout        (dout),
        .pdis        (pdis),
        .psel        (psel),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up)
    );

endmodule

// File: tb/tb_safe_gpio_port.sv
`timescale 1ns/1ps
module tb_safe_gpio_port;

    localparam int PINS   = 8;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_DIR  = 5'h00;
    localparam logic [ADDR_W-1:0] A_DIN  = 5'h04;
    localparam logic [ADDR_W-1:0] A_DOUT = 5'h08;
    localparam logic [ADDR_W-1:0] A_SET  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_CLR  = 5'h10;
    localparam logic [ADDR_W-1:0] A_PDIS = 5'h14;
    localparam logic [ADDR_W-1:0] A_PSEL = 5'h18;

    localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_PEN = 3, K_PUP = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [PINS-1:0]   wr_data;
    logic [PINS-1:0]   rd_data;
    logic [PINS-1:0]   pad_in;
    logic [PINS-1:0]   pad_oe, pad_out, pad_pull_en, pad_pull_up;

    safe_gpio_port #(.PINS(PINS), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        int            kind;
        logic [PINS-1:0] exp;
        string         tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    // Monitor: every expected item is due at the next falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [PINS-1:0] act;
            it = q.pop_front();
            case (it.kind)
                K_RD:    act = rd_data;
                K_OE:    act = pad_oe;
                K_OUT:   act = pad_out;
                K_PEN:   act = pad_pull_en;
                default: act = pad_pull_up;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_item(int kind, logic [PINS-1:0] exp, string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic expect_pads(logic [PINS-1:0] oe, logic [PINS-1:0] out,
                               logic [PINS-1:0] pen, logic [PINS-1:0] pup, string tag);
        expect_item(K_OE, oe, tag);
        expect_item(K_OUT, out, tag);
        expect_item(K_PEN, pen, tag);
        expect_item(K_PUP, pup, tag);
    endtask

    task automatic bus_wr(logic [ADDR_W-1:0] a, logic [PINS-1:0] d);
        step();
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic bus_rd(logic [ADDR_W-1:0] a, logic [PINS-1:0] exp, string tag);
        step();
        addr = a;
        expect_item(K_RD, exp, tag);
    endtask

    initial begin
        rst_n   = 1'b0;
        addr    = '0;
        wr_en   = 1'b0;
        wr_data = '0;
        pad_in  = 8'h3C;

        repeat (3) step();
        expect_pads(8'h00, 8'h00, 8'hFF, 8'h00, "R1 R2 power-up reset");

        step();
        rst_n = 1'b1;
        expect_pads(8'h00, 8'h00, 8'hFF, 8'h00, "R11 first cycle after release");

        bus_rd(A_DIR,  8'h00, "R3 dir reset");
        bus_rd(A_DOUT, 8'h00, "R3 dout reset");
        bus_rd(A_PDIS, 8'h00, "R3 pdis reset");
        bus_rd(A_PSEL, 8'h00, "R3 psel reset");
        bus_rd(A_DIN,  8'h3C, "R8 steady input");

        // Output data masked while pins are inputs
        bus_wr(A_DOUT, 8'hA5);
        expect_pads(8'h00, 8'h00, 8'hFF, 8'h00, "R4 dout masked by dir=0");
        bus_rd(A_DOUT, 8'hA5, "R4 dout held");

        bus_wr(A_DIR, 8'h0F);
        expect_pads(8'h0F, 8'h05, 8'hF0, 8'h00, "R4 R9 lower nibble output");

        bus_wr(A_PDIS, 8'h30);
        expect_item(K_PEN, 8'hC0, "R9 pull disable");
        bus_wr(A_PSEL, 8'h81);
        expect_item(K_PUP, 8'h81, "R9 pull select");

        // Atomic set / clear
        bus_wr(A_SET, 8'h50);
        bus_rd(A_SET, 8'hF5, "R5 R7 set then read at set");
        expect_item(K_OUT, 8'h05, "R4 set bits on inputs masked");
        bus_wr(A_CLR, 8'h81);
        bus_rd(A_CLR, 8'h74, "R6 R7 clear then read at clear");
        expect_item(K_OUT, 8'h04, "R6 cleared output pin");
        bus_wr(A_SET, 8'h00);
        bus_rd(A_DOUT, 8'h74, "R5 zero set write no change");
        bus_wr(A_CLR, 8'h00);
        bus_rd(A_DOUT, 8'h74, "R6 zero clear write no change");

        // Ignored writes and unmapped reads
        bus_wr(A_DIN, 8'hFF);
        bus_rd(A_DOUT, 8'h74, "R10 din write ignored dout");
        bus_rd(A_DIR,  8'h0F, "R10 din write ignored dir");
        bus_wr(5'h1C, 8'hFF);
        bus_wr(5'h01, 8'hFF);
        bus_rd(A_DIR,  8'h0F, "R10 unmapped write ignored");
        bus_rd(A_PDIS, 8'h30, "R10 misaligned write ignored");
        bus_rd(5'h1C,  8'h00, "R10 unmapped read zero");
        bus_rd(5'h09,  8'h00, "R10 misaligned read zero");

        // Input synchronizer latency
        step();
        pad_in = 8'hC3;
        addr   = A_DIN;
        expect_item(K_RD, 8'h3C, "R8 old value after E0");
        step();
        expect_item(K_RD, 8'h3C, "R8 old value after E1");
        step();
        expect_item(K_RD, 8'hC3, "R8 new value after E2");
        step();
        pad_in = 8'h5A;
        step();
        step();
        expect_item(K_RD, 8'h5A, "R8 second pattern");

        // Reset with every register non-zero
        bus_wr(A_DIR,  8'hFF);
        bus_wr(A_DOUT, 8'hFF);
        bus_wr(A_PSEL, 8'hFF);
        bus_wr(A_PDIS, 8'hFF);
        expect_pads(8'hFF, 8'hFF, 8'h00, 8'hFF, "R4 R9 all outputs high");
        step();
        rst_n = 1'b0;
        expect_pads(8'h00, 8'h00, 8'hFF, 8'h00, "R1 R2 reset over configured regs");
        step();
        expect_pads(8'h00, 8'h00, 8'hFF, 8'h00, "R1 R2 reset held");
        step();
        rst_n = 1'b1;
        expect_pads(8'h00, 8'h00, 8'hFF, 8'h00, "R11 release after config");
        bus_rd(A_DIR,  8'h00, "R3 dir cleared by reset");
        bus_rd(A_DOUT, 8'h00, "R3 dout cleared by reset");
        bus_rd(A_PSEL, 8'h00, "R3 psel cleared by reset");
        bus_rd(A_PDIS, 8'h00, "R3 pdis cleared by reset");

        step();
        step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule